// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital control for a 10-bit successive-approximation converter that watches slowly changing monitor signals such as die temperature or sensor leakage. It picks one channel on an analog input multiplexer and waits for a start request. It then performs a binary search, one bit per clock. On each search step it puts a trial code on the internal DAC and uses the single comparator decision to keep or drop the bit under test. When the search ends it stores the code in a result register and lowers its busy status.

Each conversion has a fixed length of twelve clocks. The first clock lets the multiplexer and the sampling stage settle. The next ten clocks each decide one bit, most significant bit first. The last clock latches the result. The comparator, the DAC and the reference are analog parts outside this block. Code 0 stands for 0 V and the all-ones code stands for the reference voltage. A master enable gates every action: while it is low the sequencer stays idle, and dropping it in the middle of a conversion stops that conversion.

Top module: `sar_seq_ctrl`

## Requirements
- R1: After reset, `busy`, `sample_en`, `dac_code` and `result` are all zero.
- R2: With an ideal comparator (`cmp_hi` = input ≥ `dac_code`), `result` equals the input code. This holds at both ends of the range, 0 and 1023.
- R3: `busy` is high for exactly 12 clock cycles per conversion. `result` changes only on the edge where `busy` falls.
- R4: The first trial code on `dac_code` is 0x200, with only the MSB set, during the sample cycle and the first decision cycle.
- R5: At each decision edge, the bit under test is kept when `cmp_hi` is 1 and cleared when it is 0. The next lower bit is set for the following trial.
- R6: `mux_sel` takes the `chan_sel` value present at the accepted start and holds it for the whole conversion.
- R7: A `start` request while `busy` is high is ignored. It does not change the result, the channel or the timing.
- R8: `enable` low at a clock edge returns the sequencer to idle. After that edge `busy` is 0 and `dac_code` is 0, and `result` keeps its previous value.
- R9: `start` has no effect while `enable` is low.
- R10: `sample_en` is high only in the first cycle of a conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Synchronous reset, active low |
| enable | input | 1 | Master enable; low aborts and holds idle |
| start | input | 1 | Conversion request, sampled while idle |
| chan_sel | input | CHAN_W | Channel requested for the next conversion |
| cmp_hi | input | 1 | Comparator decision: input at or above the DAC level |
| mux_sel | output | CHAN_W | Channel driven to the analog multiplexer |
| sample_en | output | 1 | High during the sampling cycle |
| dac_code | output | RES_BITS | Trial code for the DAC |
| result | output | RES_BITS | Last completed conversion code |
| busy | output | 1 | Status: conversion in progress |

## Verification
The checker watches several properties on every cycle. It checks the twelve-cycle length of each completed busy run and that `result` changes only when busy falls. It checks that the multiplexer code stays stable during a conversion and that busy is low after any edge where enable is low. It also checks that the sample strobe appears only at the start of a run and that the first trial code is the MSB alone. The bench scenarios cover the rest. They recompute the expected trial code for every decision cycle and compare the final code for several inputs and channels, including both range ends. They also cover the cases where a request must not act: a start while busy, a start while disabled, and a mid-conversion abort that must leave the earlier result in place.

// File: rtl/sar_pkg.sv
// Shared definitions for the conversion sequencer.
package sar_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SAMPLE = 2'd1,
        ST_DECIDE = 2'd2,
        ST_LATCH  = 2'd3
    } sar_state_t;
endpackage

// File: rtl/sar_chan_hold.sv
// Channel holding register.
// Captures the requested channel when a conversion is accepted and drives
// it to the analog multiplexer until the next accepted start.
// Assumes: load is a single-cycle pulse from the sequencer.
module sar_chan_hold #(
    parameter int CHAN_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [CHAN_W-1:0] chan_sel,
    output logic [CHAN_W-1:0] mux_sel
);
    // Capture the channel on an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mux_sel <= '0;
        else if (load)
            mux_sel <= chan_sel;
    end
endmodule

// File: rtl/sar_approx_reg.sv
// Successive-approximation register.
// Holds the trial code, a one-hot pointer to the bit under test, and the
// committed result. Each step resolves the pointed bit from the comparator
// and sets the next lower bit as the new trial.
// Assumes: load, step and commit are mutually exclusive; clear has priority.
module sar_approx_reg #(
    parameter int RES_BITS = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic                load,
    input  logic                step,
    input  logic                commit,
    input  logic                cmp_hi,
    output logic [RES_BITS-1:0] trial,
    output logic [RES_BITS-1:0] result,
    output logic                last_bit
);
    localparam logic [RES_BITS-1:0] MSB_ONE = {1'b1, {(RES_BITS-1){1'b0}}};

    logic [RES_BITS-1:0] ptr;
    logic [RES_BITS-1:0] trial_nxt;

    // Next trial bits, one slice per bit position.
    for (genvar i = 0; i < RES_BITS; i++) begin : g_bit
        if (i == RES_BITS - 1) begin : g_top
            always_comb trial_nxt[i] = ptr[i] ? cmp_hi : trial[i];
        end else begin : g_low
            always_comb trial_nxt[i] = ptr[i]   ? cmp_hi :
                                       ptr[i+1] ? 1'b1   : trial[i];
        end
    end

    // Trial code and bit pointer update.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            trial <= '0;
            ptr   <= '0;
        end else if (load) begin
            trial <= MSB_ONE;
            ptr   <= MSB_ONE;
        end else if (step) begin
            trial <= trial_nxt;
            ptr   <= ptr >> 1;
        end
    end

    // Result register, written once per completed conversion.
    always_ff @(posedge clk) begin
        if (!rst_n)
            result <= '0;
        else if (commit && !clear)
            result <= trial;
    end

    // Flag the final decision step.
    always_comb last_bit = ptr[0];
endmodule

// File: rtl/sar_fsm.sv
// Conversion sequencer state machine.
// Steps idle -> sample -> decide (one bit per cycle) -> latch -> idle and
// issues the control strobes for the approximation and channel registers.
// Assumes: last_bit marks the cycle of the final decision.
module sar_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic start,
    input  logic last_bit,
    output logic load,
    output logic step,
    output logic commit,
    output logic clear,
    output logic busy,
    output logic sample_en
);
    import sar_pkg::*;

    sar_state_t state, state_nxt;

    // Next-state selection.
    always_comb begin
        state_nxt = state;
        if (!enable)
            state_nxt = ST_IDLE;
        else begin
            case (state)
                ST_IDLE:   if (start) state_nxt = ST_SAMPLE;
                ST_SAMPLE: state_nxt = ST_DECIDE;
                ST_DECIDE: if (last_bit) state_nxt = ST_LATCH;
                ST_LATCH:  state_nxt = ST_IDLE;
                default:   state_nxt = ST_IDLE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nxt;
    end

    // Strobes decoded from the present state.
    always_comb begin
        clear     = !enable;
        load      = enable && start && (state == ST_IDLE);
        step      = enable && (state == ST_DECIDE);
        commit    = enable && (state == ST_LATCH);
        busy      = (state != ST_IDLE);
        sample_en = (state == ST_SAMPLE);
    end
endmodule

// File: rtl/sar_seq_ctrl.sv
// Top of the successive-approximation conversion sequencer.
// Connects the state machine, the channel holding register and the
// approximation register. A conversion lasts RES_BITS+2 cycles.
// Assumes: cmp_hi is valid in every decision cycle for the current dac_code.
module sar_seq_ctrl #(
    parameter int RES_BITS = 10,
    parameter int CHAN_W   = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic                start,
    input  logic [CHAN_W-1:0]   chan_sel,
    input  logic                cmp_hi,
    output logic [CHAN_W-1:0]   mux_sel,
    output logic                sample_en,
    output logic [RES_BITS-1:0] dac_code,
    output logic [RES_BITS-1:0] result,
    output logic                busy
);
    logic load, step, commit, clear, last_bit;

    sar_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .start     (start),
        .last_bit  (last_bit),
        .load      (load),
        .step      (step),
        .commit    (commit),
        .clear     (clear),
        .busy      (busy),
        .sample_en (sample_en)
    );

    sar_chan_hold #(.CHAN_W(CHAN_W)) u_chan (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .chan_sel (chan_sel),
        .mux_sel  (mux_sel)
    );

    sar_approx_reg #(.RES_BITS(RES_BITS)) u_sar (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (clear),
        .load     (load),
        .step     (step),
        .commit   (commit),
        .cmp_hi   (cmp_hi),
        .trial    (dac_code),
        .result   (result),
        .last_bit (last_bit)
    );
endmodule

// File: rtl/sar_seq_ctrl_chk.sv
// Property checker for the conversion sequencer, bound to every instance.
// Counts busy cycles itself so that no long $past window is needed.
module sar_seq_ctrl_chk #(
    parameter int RES_BITS = 10,
    parameter int CHAN_W   = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic                enable,
    input logic [CHAN_W-1:0]   mux_sel,
    input logic                sample_en,
    input logic [RES_BITS-1:0] dac_code,
    input logic [RES_BITS-1:0] result,
    input logic                busy
);
    localparam int CONV_CYC = RES_BITS + 2;
    localparam int CNT_W    = $clog2(CONV_CYC + 2);
    localparam logic [RES_BITS-1:0] MSB_ONE = {1'b1, {(RES_BITS-1){1'b0}}};

    logic [CNT_W-1:0] run_len;

    // Length of the current busy run.
    always_ff @(posedge clk) begin
        if (!rst_n)
            run_len <= '0;
        else if (busy)
            run_len <= run_len + 1'b1;
        else
            run_len <= '0;
    end

    p_conv_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && $past(enable)) |-> (run_len == CNT_W'(CONV_CYC)));

    p_result_update_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result) |-> $fell(busy));

    p_chan_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(mux_sel));

    p_abort_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!busy && dac_code == '0));

    p_sample_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sample_en |-> (busy && run_len == '0));

    p_msb_trial_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sample_en |-> (dac_code == MSB_ONE));
endmodule

bind sar_seq_ctrl sar_seq_ctrl_chk #(.RES_BITS(RES_BITS), .CHAN_W(CHAN_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .mux_sel   (mux_sel),
    .sample_en (sample_en),
    .dac_code  (dac_code),
    .result    (result),
    .busy      (busy)
);

// File: tb/sar_seq_ctrl_tb.sv
// Directed bench: an ideal comparator compares a per-channel input code
// against dac_code. Outputs are sampled on the falling clock edge.
module sar_seq_ctrl_tb;
    localparam int RES = 10;
    localparam int CW  = 3;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           enable = 1'b0;
    logic           start = 1'b0;
    logic [CW-1:0]  chan_sel = '0;
    logic           cmp_hi;
    logic [CW-1:0]  mux_sel;
    logic           sample_en;
    logic [RES-1:0] dac_code;
    logic [RES-1:0] result;
    logic           busy;
    logic [RES-1:0] vin [8];

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    assign cmp_hi = (vin[mux_sel] >= dac_code);

    sar_seq_ctrl #(.RES_BITS(RES), .CHAN_W(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .start(start),
        .chan_sel(chan_sel), .cmp_hi(cmp_hi), .mux_sel(mux_sel),
        .sample_en(sample_en), .dac_code(dac_code), .result(result), .busy(busy)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // R1: reset state
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        enable = 1'b1;
        @(negedge clk);
        check("R1 busy", busy, 0);
        check("R1 sample_en", sample_en, 0);
        check("R1 dac_code", dac_code, 0);
        check("R1 result", result, 0);
    endtask

    // R2..R7, R10: full conversion with per-cycle trial trace;
    // poke=1 issues a second start with another channel mid-conversion.
    task automatic t_convert(input int ch, input bit poke);
        int trial = 1 << (RES - 1);
        int b = RES - 1;
        int cyc = 0;
        int v = vin[ch];
        int old_res = result;
        bit res_early = 0;
        @(negedge clk);
        chan_sel = CW'(ch);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chan_sel = CW'(ch + 1);
        while (busy && cyc < 20) begin
            cyc++;
            check("R10 sample_en", sample_en, (cyc == 1) ? 1 : 0);
            check("R6 mux_sel", mux_sel, ch);
            if (cyc <= 2)
                check("R4 first trial", dac_code, 1 << (RES - 1));
            else
                check("R5 trial code", dac_code, trial);
            if (result != old_res) res_early = 1;
            if (poke && cyc == 5) start = 1'b1;
            if (poke && cyc == 6) start = 1'b0;
            if (cyc >= 2 && cyc <= RES + 1) begin
                if (v < trial) trial = trial & ~(1 << b);
                if (b > 0) trial = trial | (1 << (b - 1));
                b--;
            end
            @(negedge clk);
        end
        start = 1'b0;
        check("R3 busy cycles", cyc, RES + 2);
        check("R3 no early result", res_early, 0);
        check("R2 result", result, v);
        if (poke) begin
            repeat (3) @(negedge clk);
            check("R7 no restart", busy, 0);
            check("R7 result kept", result, v);
        end
    endtask

    // R8: abort mid-conversion keeps old result
    task automatic t_abort(input int ch);
        int old_res = result;
        @(negedge clk);
        chan_sel = CW'(ch);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (4) @(negedge clk);
        check("R8 busy before abort", busy, 1);
        enable = 1'b0;
        @(negedge clk);
        check("R8 busy after abort", busy, 0);
        check("R8 dac_code after abort", dac_code, 0);
        check("R8 result kept", result, old_res);
        enable = 1'b1;
        repeat (14) @(negedge clk);
        check("R8 stays idle", busy, 0);
        check("R8 result still kept", result, old_res);
    endtask

    // R9: start ignored while disabled
    task automatic t_start_disabled();
        int old_res = result;
        @(negedge clk);
        enable = 1'b0;
        chan_sel = 3'd4;
        start = 1'b1;
        repeat (3) @(negedge clk);
        check("R9 busy while disabled", busy, 0);
        start = 1'b0;
        enable = 1'b1;
        repeat (14) @(negedge clk);
        check("R9 no conversion", busy, 0);
        check("R9 result kept", result, old_res);
    endtask

    int cyc_wd = 0;
    always @(posedge clk) begin
        cyc_wd++;
        if (cyc_wd > 100000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc_wd, 100000);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        vin[0] = 10'h155; vin[1] = 10'h2AA; vin[2] = 10'd0;   vin[3] = 10'd1023;
        vin[4] = 10'd512; vin[5] = 10'd511; vin[6] = 10'd1;   vin[7] = 10'd777;
        t_reset();
        t_convert(0, 0);
        t_convert(1, 0);
        t_convert(2, 0);
        t_convert(3, 0);
        t_convert(4, 0);
        t_convert(5, 0);
        t_convert(6, 1);
        t_abort(7);
        t_start_disabled();
        t_convert(7, 0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule